// File: doc/BRIEF.md
# Single-Wire Bus Identity and Address-Phase Controller

This block is the address stage of a slave on a single-wire, multidrop serial bus. It holds a 64-bit identity built from an 8-bit family byte, a 48-bit serial number and an 8-bit check byte. After each bus reset it takes one 8-bit command and either reports the identity, checks an identity sent by the master, selects the device at once, or joins the arbitration that lets a master find every device on the bus. When it finishes, it either raises a select line for the memory-command layer or stays silent until the next bus reset.

The block works one bit at a time. A slot-timing front end gives it a strobe with each received bit. It takes each bit the block wants to send from a request/value pair and answers with a done strobe. The check byte is not stored. After chip reset, a serial shift-register generator computes it from the family byte and serial number. The generator then verifies it by shifting it back to zero. No identity bit goes out until that check is done.

Top module: `owr_rom_ctrl`

## Requirements
- R1: After chip reset, and before any bus reset, `dev_select` and `tx_req` are both 0.
- R2: After a bus reset, the next 8 bits on `rx_bit` form the command byte, least significant bit first. Command 33h sends all 64 identity bits, least significant bit first: bit 0 of the family byte first, then the serial number, then the check byte. After the last bit is acknowledged, `dev_select` goes to 1.
- R3: The check byte is the remainder under x^8+x^5+x^4+1. The register starts at zero and takes the 56 bits of the family byte and serial number, least significant bit first. The family byte defaults to 06h.
- R4: `tx_req` stays 0 until the internal check-byte computation and its zero-remainder check have both completed after chip reset. This takes 64 clock cycles.
- R5: Command 55h is followed by 64 received bits. If all 64 equal the identity, `dev_select` goes to 1 on the cycle after the last one.
- R6: After command 55h, any received bit that differs from the identity makes the block silent until the next bus reset. `dev_select` and `tx_req` then stay 0, whatever bits follow.
- R7: Command CCh sets `dev_select` on the cycle after the eighth command bit, with no identity bits exchanged.
- R8: Command F0h runs three steps for each identity bit, in order: send the bit, send its complement, then receive the master's bit. If the master's bit equals the device's bit for all 64 bits, `dev_select` goes to 1.
- R9: During command F0h, if the master's bit differs from the device's bit, the block drops out. It requests no further transmissions and does not select until the next bus reset.
- R10: Any other command value leaves the block silent and deselected until the next bus reset.
- R11: A one-cycle `bus_reset` pulse in any state clears `dev_select` and `tx_req` on the next cycle and restarts command reception.
- R12: While `tx_req` is 1 and `tx_done` has not been given, `tx_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was seen on the line |
| rx_valid | input | 1 | Strobe: one bit was received from the master |
| rx_bit | input | 1 | Value of the received bit |
| tx_done | input | 1 | Strobe: the requested bit has been sent |
| tx_req | output | 1 | Request to send one bit in the next read slot |
| tx_bit | output | 1 | Value of the bit to send |
| dev_select | output | 1 | Device selected; memory commands may follow |

## Verification
The bound checker watches four things on every cycle: the handshake and interlock rules around transmission, the select line, and bus reset. It checks that `tx_bit` is held until acknowledged, that nothing is sent before the check byte is verified or while selected, that a bus reset clears the outputs, and that selection only follows a bit event. The value of each identity bit, the check byte, and the order of bits within each command can only be shown by the bench's directed scenarios. The same holds for the drop-out and silence after a mismatch or unknown code. The bench compares these against a code it computes itself.

// File: rtl/owr_pkg.sv
package owr_pkg;

  localparam logic [7:0] CMD_READ_ID   = 8'h33;
  localparam logic [7:0] CMD_MATCH_ID  = 8'h55;
  localparam logic [7:0] CMD_SKIP_ID   = 8'hCC;
  localparam logic [7:0] CMD_SEARCH_ID = 8'hF0;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_BIT,
    ST_SRCH_INV,
    ST_SRCH_PICK,
    ST_SEL,
    ST_QUIET
  } owr_state_e;

endpackage

// File: rtl/owr_crc_gen.sv
module owr_crc_gen #(
  parameter int DATA_W = 56,
  parameter int CRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_ok
);
  import owr_pkg::*;

  localparam int TOTAL  = DATA_W + CRC_W;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int DIDX_W = $clog2(DATA_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] cap_q, cap_d;
  logic             ok_q, ok_d;
  logic             run;
  logic             in_bit;
  logic             fb;

  always_comb begin
    run    = (cnt_q < CNT_W'(TOTAL));
    in_bit = (cnt_q < CNT_W'(DATA_W)) ? data_in[cnt_q[DIDX_W-1:0]] : crc_q[0];
    fb     = crc_q[0] ^ in_bit;
    crc_d  = crc_q;
    cnt_d  = cnt_q;
    cap_d  = cap_q;
    ok_d   = ok_q;
    if (run) begin
      crc_d = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? CRC_POLY_REFL : '0);
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DATA_W)) begin
        cap_d = crc_q;
      end
      if (cnt_q == CNT_W'(TOTAL - 1)) begin
        ok_d = (crc_d == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= '0;
      cap_q <= '0;
      ok_q  <= 1'b0;
    end else if (run) begin
      cnt_q <= cnt_d;
      crc_q <= crc_d;
      cap_q <= cap_d;
      ok_q  <= ok_d;
    end
  end

  assign crc_out = cap_q;
  assign crc_ok  = ok_q;

endmodule

// File: rtl/owr_rom_seq.sv
module owr_rom_seq #(
  parameter int CODE_W = 64,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              rx_valid,
  input  logic              rx_bit,
  input  logic              tx_done,
  input  logic              crc_ok,
  input  logic [CODE_W-1:0] code,
  output logic              tx_req,
  output logic              tx_bit,
  output logic              dev_select
);
  import owr_pkg::*;

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);
  localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);

  owr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             id_bit;
  logic             tx_ack;
  logic             wants_tx;

  assign id_bit   = code[idx_q];
  assign wants_tx = (state_q == ST_READ) || (state_q == ST_SRCH_BIT) ||
                    (state_q == ST_SRCH_INV);
  assign tx_req   = wants_tx && crc_ok;
  assign tx_bit   = (state_q == ST_SRCH_INV) ? ~id_bit : id_bit;
  assign tx_ack   = tx_req && tx_done;
  assign dev_select = (state_q == ST_SEL);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cmd_d   = cmd_q;
    if (bus_reset) begin
      state_d = ST_CMD;
      idx_d   = '0;
      cmd_d   = '0;
    end else begin
      unique case (state_q)
        ST_CMD: begin
          if (rx_valid) begin
            cmd_d = {rx_bit, cmd_q[CMD_W-1:1]};
            idx_d = idx_q + 1'b1;
            if (idx_q == LAST_CMD) begin
              idx_d = '0;
              unique case (cmd_d)
                CMD_READ_ID:   state_d = ST_READ;
                CMD_MATCH_ID:  state_d = ST_MATCH;
                CMD_SKIP_ID:   state_d = ST_SEL;
                CMD_SEARCH_ID: state_d = ST_SRCH_BIT;
                default:       state_d = ST_QUIET;
              endcase
            end
          end
        end
        ST_READ: begin
          if (tx_ack) begin
            if (idx_q == LAST_IDX) state_d = ST_SEL;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        ST_MATCH: begin
          if (rx_valid) begin
            if (rx_bit != id_bit)       state_d = ST_QUIET;
            else if (idx_q == LAST_IDX) state_d = ST_SEL;
            else                        idx_d   = idx_q + 1'b1;
          end
        end
        ST_SRCH_BIT: begin
          if (tx_ack) state_d = ST_SRCH_INV;
        end
        ST_SRCH_INV: begin
          if (tx_ack) state_d = ST_SRCH_PICK;
        end
        ST_SRCH_PICK: begin
          if (rx_valid) begin
            if (rx_bit != id_bit) begin
              state_d = ST_QUIET;
            end else if (idx_q == LAST_IDX) begin
              state_d = ST_SEL;
            end else begin
              idx_d   = idx_q + 1'b1;
              state_d = ST_SRCH_BIT;
            end
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cmd_q   <= cmd_d;
    end
  end

endmodule

// File: rtl/owr_rom_ctrl.sv
module owr_rom_ctrl #(
  parameter int          FAM_W       = 8,
  parameter int          SER_W       = 48,
  parameter logic [7:0]  FAMILY_CODE = 8'h06,
  parameter logic [47:0] SERIAL_NUM  = 48'hA1B2_C3D4_E5F6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_done,
  output logic tx_req,
  output logic tx_bit,
  output logic dev_select
);

  localparam int CRC_W  = 8;
  localparam int DATA_W = FAM_W + SER_W;
  localparam int CODE_W = DATA_W + CRC_W;

  logic [DATA_W-1:0] id_data;
  logic [CRC_W-1:0]  crc_byte;
  logic              crc_ok;
  logic [CODE_W-1:0] id_code;

  assign id_data = {SERIAL_NUM[SER_W-1:0], FAMILY_CODE[FAM_W-1:0]};
  assign id_code = {crc_byte, id_data};

  owr_crc_gen #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (id_data),
    .crc_out (crc_byte),
    .crc_ok  (crc_ok)
  );

  owr_rom_seq #(
    .CODE_W (CODE_W),
    .CMD_W  (8)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .rx_valid   (rx_valid),
    .rx_bit     (rx_bit),
    .tx_done    (tx_done),
    .crc_ok     (crc_ok),
    .code       (id_code),
    .tx_req     (tx_req),
    .tx_bit     (tx_bit),
    .dev_select (dev_select)
  );

endmodule

// File: rtl/owr_rom_chk.sv
module owr_rom_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic rx_valid,
  input logic tx_done,
  input logic tx_req,
  input logic tx_bit,
  input logic dev_select,
  input logic crc_ok
);

  // R11: bus reset clears select
  a_r11_select_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !dev_select);

  // R11: bus reset cancels transmission requests
  a_r11_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !tx_req);

  // R12: requested bit held until acknowledged
  a_r12_tx_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && !bus_reset) |=> (tx_req && $stable(tx_bit)));

  // R4: nothing sent before the check byte is verified
  a_r4_tx_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> crc_ok);

  // R7: a selected device transmits nothing at address level
  a_r7_selected_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dev_select |-> !tx_req);

  // R5: selection only follows a received or sent bit
  a_r5_select_on_bit_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_select) |-> $past(rx_valid || tx_done));

endmodule

bind owr_rom_ctrl owr_rom_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_reset  (bus_reset),
  .rx_valid   (rx_valid),
  .tx_done    (tx_done),
  .tx_req     (tx_req),
  .tx_bit     (tx_bit),
  .dev_select (dev_select),
  .crc_ok     (crc_ok)
);

// File: tb/owr_rom_ctrl_test.sv
`timescale 1ns/1ps
module owr_rom_ctrl_test;

  localparam logic [7:0]  FAM = 8'h06;
  localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;

  logic clk, rst_n, bus_reset, rx_valid, rx_bit, tx_done;
  logic tx_req, tx_bit, dev_select;

  int checks = 0;
  int errors = 0;
  logic [63:0] code_exp;

  owr_rom_ctrl #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .tx_done(tx_done), .tx_req(tx_req), .tx_bit(tx_bit),
    .dev_select(dev_select)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] calc_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic get_bit(output logic b, output bit got);
    got = 1'b0; b = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (tx_req) begin got = 1'b1; break; end
      @(negedge clk);
    end
    if (got) begin
      b = tx_bit;
      tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
    end
  endtask

  task automatic t_reset_and_read();
    logic [63:0] got_code;
    logic b, b0; bit g;
    bit all_got = 1'b1, held = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dev_select == 1'b0 && tx_req == 1'b0, "R1", {tx_req, dev_select}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dev_select == 1'b0 && tx_req == 1'b0, "R1", {tx_req, dev_select}, 0);
    pulse_bus_reset();
    send_byte(8'h33);
    chk(tx_req == 1'b0, "R4 early", tx_req, 0);
    got_code = '0;
    for (int i = 0; i < 64; i++) begin
      if (i == 0) begin
        for (int w = 0; w < 200 && !tx_req; w++) @(negedge clk);
        b0 = tx_bit;
        repeat (3) begin
          @(negedge clk);
          if (tx_bit !== b0 || !tx_req) held = 1'b0;
        end
      end
      get_bit(b, g);
      if (!g) all_got = 1'b0;
      got_code[i] = b;
    end
    chk(held, "R12", {63'd0, held}, 1);
    chk(all_got, "R2 bits", {63'd0, all_got}, 1);
    chk(got_code[55:0] == code_exp[55:0], "R2 id", got_code, code_exp);
    chk(got_code[63:56] == code_exp[63:56], "R3 crc", got_code[63:56], code_exp[63:56]);
    chk(got_code[7:0] == 8'h06, "R3 family", got_code[7:0], 8'h06);
    chk(dev_select == 1'b1, "R2 select", dev_select, 1);
  endtask

  task automatic t_match_ok();
    pulse_bus_reset();
    chk(dev_select == 1'b0, "R11 clear", dev_select, 0);
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk(dev_select == 1'b0, "R5 before", dev_select, 0);
      send_bit(code_exp[i]);
    end
    chk(dev_select == 1'b1, "R5", dev_select, 1);
  endtask

  task automatic t_match_bad();
    pulse_bus_reset();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(i == 10 ? ~code_exp[i] : code_exp[i]);
    repeat (4) @(negedge clk);
    chk(dev_select == 1'b0 && tx_req == 1'b0, "R6", {tx_req, dev_select}, 0);
  endtask

  task automatic t_skip();
    pulse_bus_reset();
    for (int i = 0; i < 7; i++) send_bit(logic'(8'hCC >> i));
    chk(dev_select == 1'b0, "R7 before", dev_select, 0);
    send_bit(1'b1);
    chk(dev_select == 1'b1, "R7", dev_select, 1);
  endtask

  task automatic t_search_ok();
    logic b1, b2; bit g1, g2;
    bit ok = 1'b1;
    pulse_bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      get_bit(b1, g1);
      get_bit(b2, g2);
      if (!g1 || !g2 || b1 !== code_exp[i] || b2 !== ~code_exp[i]) ok = 1'b0;
      send_bit(code_exp[i]);
    end
    chk(ok, "R8 pattern", {63'd0, ok}, 1);
    chk(dev_select == 1'b1, "R8 select", dev_select, 1);
  endtask

  task automatic t_search_bad();
    logic b1, b2; bit g1, g2;
    bit quiet = 1'b1;
    pulse_bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      get_bit(b1, g1);
      get_bit(b2, g2);
      send_bit(i == 5 ? ~code_exp[i] : code_exp[i]);
    end
    repeat (20) begin
      @(negedge clk);
      if (tx_req || dev_select) quiet = 1'b0;
    end
    chk(quiet, "R9", {63'd0, quiet}, 1);
  endtask

  task automatic t_unknown();
    pulse_bus_reset();
    send_byte(8'h5A);
    chk(dev_select == 1'b0 && tx_req == 1'b0, "R10", {tx_req, dev_select}, 0);
    send_byte(8'hCC);
    repeat (3) @(negedge clk);
    chk(dev_select == 1'b0 && tx_req == 1'b0, "R10 stays", {tx_req, dev_select}, 0);
    pulse_bus_reset();
    send_byte(8'hCC);
    chk(dev_select == 1'b1, "R11 restart", dev_select, 1);
  endtask

  task automatic t_abort();
    logic b; bit g;
    pulse_bus_reset();
    send_byte(8'h33);
    for (int i = 0; i < 4; i++) get_bit(b, g);
    chk(tx_req == 1'b1, "R2 mid", tx_req, 1);
    pulse_bus_reset();
    chk(tx_req == 1'b0 && dev_select == 1'b0, "R11 abort", {tx_req, dev_select}, 0);
    send_byte(8'hCC);
    chk(dev_select == 1'b1, "R11 skip", dev_select, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_reset = 1'b0; rx_valid = 1'b0; rx_bit = 1'b0; tx_done = 1'b0;
    code_exp = {calc_crc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    t_reset_and_read();
    t_match_ok();
    t_match_bad();
    t_skip();
    t_search_ok();
    t_search_bad();
    t_unknown();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule